// File: doc/BRIEF.md
# Display Timing Controller Port Register Front End

This block sits between a byte-wide I/O port bus and the register state of a VGA-style display timing controller. It decodes port reads and writes. It keeps a miscellaneous output byte whose lowest bit moves the index/data port pair between a monochrome base and a color base. Through that pair it gives access to a 25-entry standard timing bank and a 16-entry extended bank. The extended bank stays write-locked until software writes a two-byte password.

The block also answers with a fixed two-character signature, which lets software identify the controller generation. It runs a mode-switch handshake for software that reprograms the timing registers. Software raises a switch flag before it rewrites the registers and drops the flag afterwards. Dropping the flag raises a "validation pending" status bit. That bit clears only at the next vertical blank pulse, so software can poll it until the new register state has been taken up.

Top module: `vid_port_regs`

## Requirements
- R1: After reset the miscellaneous byte is 0x01 (color addressing), every bank register reads 0x00, the extended bank is locked, `modeSwitch`, `validPending` and `extOpen` are 0, and `portRdata` is 0x00.
- R2: A write to port 0x3C2 loads the miscellaneous byte and a read of port 0x3CC returns it. When its bit 0 is 1 the index/data ports are 0x3D4/0x3D5; when it is 0 they are 0x3B4/0x3B5. A read of the index port returns the current index.
- R3: Two consecutive data writes to index 0x30, first 0x57 and then 0x4C, unlock the extended bank. A data write of 0x00 to index 0x30 locks it again. Reading index 0x30 returns 0x01 while the bank is unlocked and 0x00 while it is locked.
- R4: After 0x57 has been written, any data value at index 0x30 other than 0x4C returns the sequence to the locked idle state, so a later 0x4C on its own does not unlock.
- R5: Data writes to indices 0x40..0x4F change the extended bank only while it is unlocked. While it is locked those writes are dropped, and reads always return the stored contents.
- R6: Indices 0x00..0x18 form the standard bank and can be read and written. While bit 7 of index 0x11 is 1, writes to indices 0x00..0x07 are dropped. Index 0x11 itself stays writable, so writing 0 to it removes the protection.
- R7: Index 0x35 reads 0x43 ('C') and index 0x36 reads 0x58 ('X'). Any other index that is not implemented reads 0x00.
- R8: Bit 0 of a data write to index 0x3F sets `modeSwitch` (1 = switch in progress), but only while the extended bank is unlocked. Index 0x3F reads back that bit.
- R9: A write that takes `modeSwitch` from 1 to 0 sets `validPending`, which index 0x33 shows in bit 7. The next `vblankPulse` clears it. If the ending write and a blank pulse come in the same cycle, the bit is still set.
- R10: Accesses to the port pair that is not selected, or to any other port, are ignored, and reads of them return 0xFF.
- R11: `portRdata` takes its new value on the clock edge at which `portRd` is sampled high, and holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| portAddr | input | 16 | I/O port address |
| portWr | input | 1 | Write strobe, one cycle per access |
| portRd | input | 1 | Read strobe, one cycle per access |
| portWdata | input | 8 | Write data |
| portRdata | output | 8 | Registered read data |
| vblankPulse | input | 1 | One-cycle vertical blank pulse |
| modeSwitch | output | 1 | Mode switch in progress |
| validPending | output | 1 | New register state waiting for vertical blank |
| extOpen | output | 1 | Extended bank unlocked |

## Verification
The bench goes after the password sequence and its broken forms. A wrong second byte followed by a correct one must leave the bank locked; a design that only looked at the last byte would unlock there. It writes the extended and protected standard registers while they are locked and reads them back. A leaky write gate shows up as a changed value. It switches to monochrome addressing to show that the color pair goes dead and reads 0xFF. It ends a mode switch in the same cycle as a blank pulse, where a design with the wrong priority would lose the pending bit.

// File: rtl/vpr_pkg.sv
package vpr_pkg;
  typedef enum logic [1:0] {
    LK_SHUT = 2'd0,
    LK_HALF = 2'd1,
    LK_OPEN = 2'd2
  } lockState_t;

  // strobes from control to datapath, all valid for one cycle
  typedef struct packed {
    logic miscWr;
    logic idxWr;
    logic stdWr;
    logic extWr;
    logic rdMisc;
    logic rdIdx;
    logic rdData;
    logic rdMiss;
  } portStrobe_t;

  localparam logic [7:0] IDX_LOCK   = 8'h30;
  localparam logic [7:0] IDX_STATUS = 8'h33;
  localparam logic [7:0] IDX_SIG0   = 8'h35;
  localparam logic [7:0] IDX_SIG1   = 8'h36;
  localparam logic [7:0] IDX_MODESW = 8'h3F;
  localparam logic [7:0] IDX_PROT   = 8'h11;
  localparam logic [7:0] KEY_FIRST  = 8'h57;
  localparam logic [7:0] KEY_SECOND = 8'h4C;
  localparam logic [7:0] SIG_CHAR0  = 8'h43;
  localparam logic [7:0] SIG_CHAR1  = 8'h58;
endpackage

// File: rtl/vpr_ctrl.sv
module vpr_ctrl
  import vpr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int STD_CNT = 25,
  parameter int PROT_CNT = 8,
  parameter int EXT_CNT = 16,
  parameter logic [7:0] EXT_BASE = 8'h40,
  parameter logic [ADDR_W-1:0] COLOR_IDX = 16'h3D4,
  parameter logic [ADDR_W-1:0] MONO_IDX = 16'h3B4,
  parameter logic [ADDR_W-1:0] MISC_WR = 16'h3C2,
  parameter logic [ADDR_W-1:0] MISC_RD = 16'h3CC
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] portAddr,
  input  logic              portWr,
  input  logic              portRd,
  input  logic [7:0]        portWdata,
  input  logic              vblankPulse,
  input  logic              colorSel,
  input  logic [7:0]        curIdx,
  input  logic              stdProtect,
  output portStrobe_t       strb,
  output logic              extOpen,
  output logic              modeSwitch,
  output logic              validPending
);
  localparam int EXT_AW = $clog2(EXT_CNT);
  localparam logic [7:0] STD_LAST = 8'(STD_CNT - 1);
  localparam logic [7:0] PROT_LAST = 8'(PROT_CNT - 1);

  lockState_t lockState;
  logic [ADDR_W-1:0] idxPort, dataPort;
  logic hitIdx, hitData, dataWr, lockWr, msWr, inExt, inStd;

  always_comb begin
    idxPort  = colorSel ? COLOR_IDX : MONO_IDX;
    dataPort = idxPort + ADDR_W'(1);
    hitIdx   = (portAddr == idxPort);
    hitData  = (portAddr == dataPort);
    dataWr   = portWr && hitData;
    inStd    = (curIdx <= STD_LAST);
    inExt    = (curIdx[7:EXT_AW] == EXT_BASE[7:EXT_AW]);
    lockWr   = dataWr && (curIdx == IDX_LOCK);
    msWr     = dataWr && (curIdx == IDX_MODESW) && extOpen;

    strb.miscWr = portWr && (portAddr == MISC_WR);
    strb.idxWr  = portWr && hitIdx;
    strb.stdWr  = dataWr && inStd && !(stdProtect && (curIdx <= PROT_LAST));
    strb.extWr  = dataWr && inExt && extOpen;
    strb.rdMisc = portRd && (portAddr == MISC_RD);
    strb.rdIdx  = portRd && hitIdx;
    strb.rdData = portRd && hitData;
    strb.rdMiss = portRd && !(portAddr == MISC_RD) && !hitIdx && !hitData;
  end

  assign extOpen = (lockState == LK_OPEN);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockState <= LK_SHUT;
    end else if (lockWr) begin
      case (lockState)
        LK_SHUT: if (portWdata == KEY_FIRST) lockState <= LK_HALF;
        LK_HALF: lockState <= (portWdata == KEY_SECOND) ? LK_OPEN : LK_SHUT;
        LK_OPEN: if (portWdata == 8'h00) lockState <= LK_SHUT;
        default: lockState <= LK_SHUT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeSwitch   <= 1'b0;
      validPending <= 1'b0;
    end else begin
      if (msWr) modeSwitch <= portWdata[0];
      if (msWr && modeSwitch && !portWdata[0]) validPending <= 1'b1;
      else if (vblankPulse) validPending <= 1'b0;
    end
  end
endmodule

// File: rtl/vpr_data.sv
module vpr_data
  import vpr_pkg::*;
#(
  parameter int STD_CNT = 25,
  parameter int EXT_CNT = 16,
  parameter logic [7:0] EXT_BASE = 8'h40
) (
  input  logic        clk,
  input  logic        rstN,
  input  portStrobe_t strb,
  input  logic [7:0]  portWdata,
  input  logic        extOpen,
  input  logic        modeSwitch,
  input  logic        validPending,
  output logic        colorSel,
  output logic [7:0]  curIdx,
  output logic        stdProtect,
  output logic [7:0]  portRdata
);
  localparam int STD_AW = $clog2(STD_CNT);
  localparam int EXT_AW = $clog2(EXT_CNT);
  localparam logic [7:0] STD_LAST = 8'(STD_CNT - 1);

  logic [7:0] miscReg;
  logic [7:0] stdBank [STD_CNT];
  logic [7:0] extBank [EXT_CNT];
  logic [7:0] dataVal;

  assign colorSel   = miscReg[0];
  assign stdProtect = stdBank[IDX_PROT[STD_AW-1:0]][7];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      miscReg <= 8'h01;
      curIdx  <= 8'h00;
    end else begin
      if (strb.miscWr) miscReg <= portWdata;
      if (strb.idxWr)  curIdx  <= portWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < STD_CNT; i++) stdBank[i] <= 8'h00;
    end else if (strb.stdWr) begin
      stdBank[curIdx[STD_AW-1:0]] <= portWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < EXT_CNT; i++) extBank[i] <= 8'h00;
    end else if (strb.extWr) begin
      extBank[curIdx[EXT_AW-1:0]] <= portWdata;
    end
  end

  always_comb begin
    if (curIdx <= STD_LAST)                             dataVal = stdBank[curIdx[STD_AW-1:0]];
    else if (curIdx[7:EXT_AW] == EXT_BASE[7:EXT_AW])    dataVal = extBank[curIdx[EXT_AW-1:0]];
    else if (curIdx == IDX_LOCK)                        dataVal = {7'b0, extOpen};
    else if (curIdx == IDX_STATUS)                      dataVal = {validPending, 7'b0};
    else if (curIdx == IDX_SIG0)                        dataVal = SIG_CHAR0;
    else if (curIdx == IDX_SIG1)                        dataVal = SIG_CHAR1;
    else if (curIdx == IDX_MODESW)                      dataVal = {7'b0, modeSwitch};
    else                                                dataVal = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            portRdata <= 8'h00;
    else if (strb.rdMisc) portRdata <= miscReg;
    else if (strb.rdIdx)  portRdata <= curIdx;
    else if (strb.rdData) portRdata <= dataVal;
    else if (strb.rdMiss) portRdata <= 8'hFF;
  end
endmodule

// File: rtl/vid_port_regs.sv
module vid_port_regs
  import vpr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int STD_CNT = 25,
  parameter int PROT_CNT = 8,
  parameter int EXT_CNT = 16,
  parameter logic [7:0] EXT_BASE = 8'h40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] portAddr,
  input  logic              portWr,
  input  logic              portRd,
  input  logic [7:0]        portWdata,
  output logic [7:0]        portRdata,
  input  logic              vblankPulse,
  output logic              modeSwitch,
  output logic              validPending,
  output logic              extOpen
);
  portStrobe_t strb;
  logic colorSel, stdProtect;
  logic [7:0] curIdx;

  vpr_ctrl #(
    .ADDR_W(ADDR_W), .STD_CNT(STD_CNT), .PROT_CNT(PROT_CNT),
    .EXT_CNT(EXT_CNT), .EXT_BASE(EXT_BASE)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .portAddr(portAddr), .portWr(portWr),
    .portRd(portRd), .portWdata(portWdata), .vblankPulse(vblankPulse),
    .colorSel(colorSel), .curIdx(curIdx), .stdProtect(stdProtect),
    .strb(strb), .extOpen(extOpen), .modeSwitch(modeSwitch),
    .validPending(validPending)
  );

  vpr_data #(
    .STD_CNT(STD_CNT), .EXT_CNT(EXT_CNT), .EXT_BASE(EXT_BASE)
  ) i_data (
    .clk(clk), .rstN(rstN), .strb(strb), .portWdata(portWdata),
    .extOpen(extOpen), .modeSwitch(modeSwitch), .validPending(validPending),
    .colorSel(colorSel), .curIdx(curIdx), .stdProtect(stdProtect),
    .portRdata(portRdata)
  );
endmodule

// File: rtl/vpr_checker.sv
module vpr_checker (
  input logic        clk,
  input logic        rstN,
  input logic [15:0] portAddr,
  input logic        portWr,
  input logic        portRd,
  input logic [7:0]  portWdata,
  input logic [7:0]  portRdata,
  input logic        vblankPulse,
  input logic        modeSwitch,
  input logic        validPending,
  input logic        extOpen
);
  logic knownPort;
  assign knownPort = (portAddr == 16'h3CC) || (portAddr == 16'h3D4) || (portAddr == 16'h3D5) ||
                     (portAddr == 16'h3B4) || (portAddr == 16'h3B5);

  // R3: the bank opens only right after a write of the second key byte
  a_r3_open_after_key: assert property (@(posedge clk) disable iff (!rstN)
    $rose(extOpen) |-> ($past(portWr) && $past(portWdata) == 8'h4C));

  // R8: the switch flag moves only while the bank is unlocked
  a_r8_switch_gated: assert property (@(posedge clk) disable iff (!rstN)
    (modeSwitch != $past(modeSwitch)) |-> $past(extOpen));

  // R9: pending rises only when a switch ends
  a_r9_pending_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(validPending) |-> ($past(modeSwitch) && !modeSwitch));

  // R9: blank pulse with no switch running clears pending
  a_r9_blank_clears: assert property (@(posedge clk) disable iff (!rstN)
    (validPending && vblankPulse && !modeSwitch) |=> !validPending);

  // R10: reads of unknown ports return all ones
  a_r10_miss_reads_ff: assert property (@(posedge clk) disable iff (!rstN)
    (portRd && !knownPort) |=> (portRdata == 8'hFF));

  // R11: read data holds without a read strobe
  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rstN)
    !portRd |=> $stable(portRdata));
endmodule

bind vid_port_regs vpr_checker i_vpr_checker (.*);

// File: tb/test_vid_port_regs.sv
module test_vid_port_regs;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] portAddr = 16'h0;
  logic portWr = 1'b0, portRd = 1'b0, vblankPulse = 1'b0;
  logic [7:0] portWdata = 8'h0;
  logic [7:0] portRdata;
  logic modeSwitch, validPending, extOpen;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  vid_port_regs i_vid_port_regs (
    .clk(clk), .rstN(rstN), .portAddr(portAddr), .portWr(portWr), .portRd(portRd),
    .portWdata(portWdata), .portRdata(portRdata), .vblankPulse(vblankPulse),
    .modeSwitch(modeSwitch), .validPending(validPending), .extOpen(extOpen)
  );

  // vector: {isRead, addr, data or expected, requirement number}
  localparam int NV = 58;
  localparam logic [32:0] VEC [NV] = '{
    {1'b1, 16'h3CC, 8'h01, 8'd2},   // R2 misc reset value
    {1'b0, 16'h3D4, 8'h11, 8'd0}, {1'b0, 16'h3D5, 8'h80, 8'd0},
    {1'b1, 16'h3D5, 8'h80, 8'd6},   // R6 protect bit stored
    {1'b0, 16'h3D4, 8'h03, 8'd0}, {1'b0, 16'h3D5, 8'hAA, 8'd0},
    {1'b1, 16'h3D5, 8'h00, 8'd6},   // R6 protected write dropped
    {1'b0, 16'h3D4, 8'h11, 8'd0}, {1'b0, 16'h3D5, 8'h00, 8'd0},
    {1'b0, 16'h3D4, 8'h03, 8'd0}, {1'b0, 16'h3D5, 8'hAA, 8'd0},
    {1'b1, 16'h3D5, 8'hAA, 8'd6},   // R6 unprotected write lands
    {1'b0, 16'h3D4, 8'h18, 8'd0}, {1'b0, 16'h3D5, 8'h5C, 8'd0},
    {1'b1, 16'h3D5, 8'h5C, 8'd6},   // R6 top of standard bank
    {1'b0, 16'h3D4, 8'h35, 8'd0},
    {1'b1, 16'h3D5, 8'h43, 8'd7},   // R7 first signature char
    {1'b0, 16'h3D4, 8'h36, 8'd0},
    {1'b1, 16'h3D5, 8'h58, 8'd7},   // R7 second signature char
    {1'b0, 16'h3D4, 8'h20, 8'd0},
    {1'b1, 16'h3D5, 8'h00, 8'd7},   // R7 unused index
    {1'b0, 16'h3D4, 8'h45, 8'd0}, {1'b0, 16'h3D5, 8'h77, 8'd0},
    {1'b1, 16'h3D5, 8'h00, 8'd5},   // R5 locked write dropped
    {1'b0, 16'h3D4, 8'h30, 8'd0},
    {1'b1, 16'h3D5, 8'h00, 8'd3},   // R3 reads locked
    {1'b0, 16'h3D5, 8'h57, 8'd0}, {1'b0, 16'h3D5, 8'h4C, 8'd0},
    {1'b1, 16'h3D5, 8'h01, 8'd3},   // R3 reads unlocked
    {1'b0, 16'h3D4, 8'h45, 8'd0}, {1'b0, 16'h3D5, 8'h77, 8'd0},
    {1'b1, 16'h3D5, 8'h77, 8'd5},   // R5 unlocked write lands
    {1'b0, 16'h3D4, 8'h30, 8'd0}, {1'b0, 16'h3D5, 8'h00, 8'd0},
    {1'b1, 16'h3D5, 8'h00, 8'd3},   // R3 relocked
    {1'b0, 16'h3D4, 8'h45, 8'd0}, {1'b0, 16'h3D5, 8'h11, 8'd0},
    {1'b1, 16'h3D5, 8'h77, 8'd5},   // R5 stored value kept and readable
    {1'b0, 16'h3D4, 8'h30, 8'd0}, {1'b0, 16'h3D5, 8'h57, 8'd0},
    {1'b0, 16'h3D5, 8'h12, 8'd0}, {1'b0, 16'h3D5, 8'h4C, 8'd0},
    {1'b1, 16'h3D5, 8'h00, 8'd4},   // R4 broken sequence stays locked
    {1'b1, 16'h3B5, 8'hFF, 8'd10},  // R10 mono pair dead in color mode
    {1'b0, 16'h3B4, 8'h03, 8'd0},
    {1'b1, 16'h3D4, 8'h30, 8'd10},  // R10 mono index write ignored
    {1'b1, 16'h3C0, 8'hFF, 8'd10},  // R10 unknown port
    {1'b0, 16'h3C2, 8'h00, 8'd0},
    {1'b1, 16'h3CC, 8'h00, 8'd2},   // R2 misc readback
    {1'b1, 16'h3D5, 8'hFF, 8'd10},  // R10 color pair dead in mono mode
    {1'b0, 16'h3B4, 8'h45, 8'd0},
    {1'b1, 16'h3B5, 8'h77, 8'd2},   // R2 mono pair reaches bank
    {1'b1, 16'h3B4, 8'h45, 8'd2},   // R2 index readback
    {1'b0, 16'h3C2, 8'h01, 8'd0},
    {1'b1, 16'h3D4, 8'h45, 8'd2},   // R2 back to color pair
    {1'b0, 16'h3D4, 8'h03, 8'd0},
    {1'b1, 16'h3D5, 8'hAA, 8'd11},  // R11 read data after strobe
    {1'b1, 16'h3CC, 8'h01, 8'd2}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    portAddr = a; portWdata = d; portWr = 1'b1;
    @(negedge clk);
    portWr = 1'b0;
  endtask

  task automatic doRead(input logic [15:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    portAddr = a; portRd = 1'b1;
    @(negedge clk);
    portRd = 1'b0;
    check(tag, portRdata, exp);
  endtask

  task automatic pulseBlank();
    @(negedge clk);
    vblankPulse = 1'b1;
    @(negedge clk);
    vblankPulse = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rdata", portRdata, 8'h00);
    check("R1 modeSwitch", {7'b0, modeSwitch}, 8'h00);
    check("R1 validPending", {7'b0, validPending}, 8'h00);
    check("R1 extOpen", {7'b0, extOpen}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][32]) doRead(VEC[i][31:16], VEC[i][15:8], $sformatf("R%0d vec%0d", VEC[i][7:0], i));
      else doWrite(VEC[i][31:16], VEC[i][15:8]);
    end

    // R11 value held with no read strobe
    repeat (3) @(negedge clk);
    check("R11 hold", portRdata, 8'h01);

    // R8 switch write while locked is ignored
    doWrite(16'h3D4, 8'h3F); doWrite(16'h3D5, 8'h01);
    check("R8 locked switch", {7'b0, modeSwitch}, 8'h00);
    doWrite(16'h3D4, 8'h30); doWrite(16'h3D5, 8'h57); doWrite(16'h3D5, 8'h4C);
    check("R3 extOpen", {7'b0, extOpen}, 8'h01);
    doWrite(16'h3D4, 8'h3F); doWrite(16'h3D5, 8'h01);
    check("R8 switch set", {7'b0, modeSwitch}, 8'h01);
    doRead(16'h3D5, 8'h01, "R8 switch readback");
    doWrite(16'h3D5, 8'h00);
    check("R9 pending set", {7'b0, validPending}, 8'h01);
    doWrite(16'h3D4, 8'h33);
    doRead(16'h3D5, 8'h80, "R9 status bit");
    pulseBlank();
    check("R9 blank clears", {7'b0, validPending}, 8'h00);
    doRead(16'h3D5, 8'h00, "R9 status cleared");

    // R9 end write together with blank pulse
    doWrite(16'h3D4, 8'h3F); doWrite(16'h3D5, 8'h01);
    @(negedge clk);
    portAddr = 16'h3D5; portWdata = 8'h00; portWr = 1'b1; vblankPulse = 1'b1;
    @(negedge clk);
    portWr = 1'b0; vblankPulse = 1'b0;
    check("R9 coincident end", {7'b0, validPending}, 8'h01);
    pulseBlank();
    check("R9 later blank", {7'b0, validPending}, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule